// File: doc/BRIEF.md
# Serial Channel Error Status Register

This block holds the status byte and the sticky error flags of one channel of a two-channel serial unit. The channel can run as a UART, as a clocked serial (CSI) link or as I2C. The shift engine of the channel sends single-cycle event strobes into the block. These report the end of a UART frame, together with its stop-bit and parity results, the I2C acknowledge sampling slot, data entering the shared data buffer, a CPU read of received data, the shift engine taking transmit data, and the start of a CSI slave transfer that needs transmit data. From these strobes the block keeps three error flags: framing, parity/acknowledge and overrun. It also reports a transfer-busy bit and a buffer-full bit.

Software reads the 8-bit status byte. It clears error flags by writing ones to a separate clear register, which always reads back as zero. A parameter gives the channel index. Only channel 1 builds the framing flag, and on channel 0 that bit is always zero.

Top module: `sercha_status`

## Requirements
- R1: After reset the status byte reads 0x00. Its layout is: bit 6 transfer-busy, bit 5 buffer-full, bit 2 framing error, bit 1 parity/acknowledge error, bit 0 overrun error. Bits 7, 4 and 3 always read 0.
- R2: On channel 1, the framing flag sets one cycle after a UART frame-end strobe that reports no valid stop bit. On channel 0, bit 2 always reads 0.
- R3: The parity/acknowledge flag sets one cycle after a UART frame-end strobe that reports a parity mismatch. A frame with good parity and a good stop bit sets no flag.
- R4: The parity/acknowledge flag sets one cycle after an acknowledge-slot strobe that occurs while I2C transmit mode is 1 and no acknowledge is seen. It does not set when an acknowledge is seen or when transmit mode is 0.
- R5: The overrun flag sets one cycle after a transmit-data write or a received-data store, if both of these hold: received data is still unread, and receive enable is 1. It does not set when receive enable is 0 or when the data has already been read.
- R6: The overrun flag sets one cycle after a CSI slave transmit start while the buffer is empty.
- R7: A write to the clear register clears each error flag whose bit is 1. The bit positions are 2, 1 and 0, as in the status byte. A bit written as 0 leaves its flag unchanged.
- R8: When a set event and a clear of the same flag arrive on the same edge, the flag ends up set.
- R9: Error flags hold until they are cleared. The clear register reads back 0x00 at all times.
- R10: Transfer-busy reflects the busy input one cycle later. Buffer-full sets on a transmit-data write or a received-data store. It clears on a CPU read or when the engine takes the data, and a set on the same edge wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_busy | input | 1 | Channel is shifting a transfer |
| rx_enable | input | 1 | Receive direction enabled |
| uart_frame_end | input | 1 | Strobe: UART frame completed |
| uart_stop_ok | input | 1 | Valid stop bit seen for this frame |
| uart_par_ok | input | 1 | Received parity matched computed parity |
| i2c_tx_mode | input | 1 | I2C channel is transmitting |
| i2c_ack_slot | input | 1 | Strobe: acknowledge sampling slot |
| i2c_ack_seen | input | 1 | Acknowledge driven low at the slot |
| tx_wr | input | 1 | Strobe: transmit data written into buffer |
| rx_store | input | 1 | Strobe: received data stored into buffer |
| cpu_rd | input | 1 | Strobe: CPU read of received data |
| tx_take | input | 1 | Strobe: engine took transmit data from buffer |
| csi_slv_tx_start | input | 1 | Strobe: CSI slave transfer with transmit part starts |
| clr_wr | input | 1 | Write strobe of the clear register |
| clr_wdata | input | 8 | Clear register write data (ones clear) |
| status | output | 8 | Status byte |
| clr_rdata | output | 8 | Clear register read value |

## Verification
The UART frame-end strobe is swept over all four stop/parity outcomes on both channel instances. This separates the framing flag from the parity flag and shows that channel 0 never raises bit 2. The acknowledge slot is swept over all combinations of transmit mode and acknowledge, which isolates the single case that should raise an error. Overrun is tried with every combination of unread data, receive enable and write kind, and with the CSI start both with and without loaded data. Clear writes are swept one bit at a time and also arrive on the same edge as a set event, which confirms that each bit is independent and that the set wins.

// File: rtl/sercha_pkg.sv
package sercha_pkg;
    // Error flag bundle; bit order matches status[2:0]
    typedef struct packed {
        logic frame;
        logic parity;
        logic ovr;
    } err_t;

    localparam int ERR_W   = 3;
    localparam int BIT_BSY = 6;
    localparam int BIT_BFL = 5;
endpackage

// File: rtl/sercha_events.sv
module sercha_events
    import sercha_pkg::*;
#(
    parameter bit HAS_FRAME = 1'b1
) (
    input  logic uart_frame_end,
    input  logic uart_stop_ok,
    input  logic uart_par_ok,
    input  logic i2c_tx_mode,
    input  logic i2c_ack_slot,
    input  logic i2c_ack_seen,
    input  logic rx_enable,
    input  logic tx_wr,
    input  logic rx_store,
    input  logic csi_slv_tx_start,
    input  logic rx_unread_q,
    input  logic buf_full_q,
    output err_t set_ev
);
    always_comb begin
        set_ev        = '0;
        set_ev.frame  = HAS_FRAME && uart_frame_end && !uart_stop_ok;
        set_ev.parity = (uart_frame_end && !uart_par_ok)
                      || (i2c_ack_slot && i2c_tx_mode && !i2c_ack_seen);
        set_ev.ovr    = (rx_enable && rx_unread_q && (tx_wr || rx_store))
                      || (csi_slv_tx_start && !buf_full_q);
    end
endmodule

// File: rtl/sercha_buftrack.sv
module sercha_buftrack (
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_busy,
    input  logic tx_wr,
    input  logic rx_store,
    input  logic cpu_rd,
    input  logic tx_take,
    output logic busy_q,
    output logic buf_full_q,
    output logic rx_unread_q
);
    typedef struct packed {
        logic busy;
        logic full;
        logic unread;
    } bt_t;

    bt_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.busy = xfer_busy;
        if (cpu_rd || tx_take) st_d.full = 1'b0;
        if (tx_wr || rx_store) st_d.full = 1'b1;
        if (cpu_rd)            st_d.unread = 1'b0;
        if (rx_store)          st_d.unread = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_q      = st_q.busy;
    assign buf_full_q  = st_q.full;
    assign rx_unread_q = st_q.unread;

    assert_full_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr || rx_store) |=> buf_full_q);
endmodule

// File: rtl/sercha_errflags.sv
module sercha_errflags
    import sercha_pkg::*;
#(
    parameter bit HAS_FRAME = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  err_t set_ev,
    input  err_t clr_ev,
    output err_t flags_q
);
    err_t fl_d, fl_q;

    always_comb begin
        // clear first, set afterwards so a coincident set wins
        fl_d = fl_q & ~clr_ev;
        fl_d = fl_d | set_ev;
    end

    generate
        if (HAS_FRAME) begin : g_frame
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) fl_q <= '0;
                else        fl_q <= fl_d;
            end
        end else begin : g_noframe
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    fl_q <= '0;
                end else begin
                    fl_q.frame  <= 1'b0;
                    fl_q.parity <= fl_d.parity;
                    fl_q.ovr    <= fl_d.ovr;
                end
            end
        end
    endgenerate

    assign flags_q = fl_q;

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ev.parity && clr_ev.parity) |=> flags_q.parity);
    assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ev.ovr && !set_ev.ovr) |=> !flags_q.ovr);
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q.parity && !clr_ev.parity) |=> flags_q.parity);
endmodule

// File: rtl/sercha_status.sv
module sercha_status
    import sercha_pkg::*;
#(
    parameter int CHAN_IDX = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xfer_busy,
    input  logic       rx_enable,
    input  logic       uart_frame_end,
    input  logic       uart_stop_ok,
    input  logic       uart_par_ok,
    input  logic       i2c_tx_mode,
    input  logic       i2c_ack_slot,
    input  logic       i2c_ack_seen,
    input  logic       tx_wr,
    input  logic       rx_store,
    input  logic       cpu_rd,
    input  logic       tx_take,
    input  logic       csi_slv_tx_start,
    input  logic       clr_wr,
    input  logic [7:0] clr_wdata,
    output logic [7:0] status,
    output logic [7:0] clr_rdata
);
    localparam bit HAS_FRAME = (CHAN_IDX == 1);

    logic busy_q, buf_full_q, rx_unread_q;
    err_t set_ev, clr_ev, flags_q;

    sercha_buftrack u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .xfer_busy   (xfer_busy),
        .tx_wr       (tx_wr),
        .rx_store    (rx_store),
        .cpu_rd      (cpu_rd),
        .tx_take     (tx_take),
        .busy_q      (busy_q),
        .buf_full_q  (buf_full_q),
        .rx_unread_q (rx_unread_q)
    );

    sercha_events #(.HAS_FRAME(HAS_FRAME)) u_ev (
        .uart_frame_end   (uart_frame_end),
        .uart_stop_ok     (uart_stop_ok),
        .uart_par_ok      (uart_par_ok),
        .i2c_tx_mode      (i2c_tx_mode),
        .i2c_ack_slot     (i2c_ack_slot),
        .i2c_ack_seen     (i2c_ack_seen),
        .rx_enable        (rx_enable),
        .tx_wr            (tx_wr),
        .rx_store         (rx_store),
        .csi_slv_tx_start (csi_slv_tx_start),
        .rx_unread_q      (rx_unread_q),
        .buf_full_q       (buf_full_q),
        .set_ev           (set_ev)
    );

    always_comb begin
        clr_ev = '0;
        if (clr_wr) clr_ev = clr_wdata[ERR_W-1:0];
    end

    sercha_errflags #(.HAS_FRAME(HAS_FRAME)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_ev  (set_ev),
        .clr_ev  (clr_ev),
        .flags_q (flags_q)
    );

    always_comb begin
        status          = '0;
        status[BIT_BSY] = busy_q;
        status[BIT_BFL] = buf_full_q;
        status[2:0]     = flags_q;
    end

    assign clr_rdata = '0;

    assert_par_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (uart_frame_end && !uart_par_ok) |=> status[1]);
    assert_ack_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (i2c_ack_slot && i2c_tx_mode && !i2c_ack_seen) |=> status[1]);
    assert_csi_ovr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (csi_slv_tx_start && !buf_full_q) |=> status[0]);
    assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_busy |=> status[BIT_BSY]);

    generate
        if (HAS_FRAME) begin : g_fa
            assert_frame_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (uart_frame_end && !uart_stop_ok) |=> status[2]);
        end
    endgenerate
endmodule

// File: tb/sercha_status_tb.sv
module sercha_status_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xfer_busy = 0, rx_enable = 0;
    logic uart_frame_end = 0, uart_stop_ok = 0, uart_par_ok = 0;
    logic i2c_tx_mode = 0, i2c_ack_slot = 0, i2c_ack_seen = 0;
    logic tx_wr = 0, rx_store = 0, cpu_rd = 0, tx_take = 0, csi_slv_tx_start = 0;
    logic clr_wr = 0;
    logic [7:0] clr_wdata = '0;
    logic [7:0] st1, st0, cr1, cr0;
    int n_chk = 0, n_err = 0;

    always #10 clk = ~clk;

    sercha_status #(.CHAN_IDX(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .xfer_busy(xfer_busy), .rx_enable(rx_enable),
        .uart_frame_end(uart_frame_end), .uart_stop_ok(uart_stop_ok), .uart_par_ok(uart_par_ok),
        .i2c_tx_mode(i2c_tx_mode), .i2c_ack_slot(i2c_ack_slot), .i2c_ack_seen(i2c_ack_seen),
        .tx_wr(tx_wr), .rx_store(rx_store), .cpu_rd(cpu_rd), .tx_take(tx_take),
        .csi_slv_tx_start(csi_slv_tx_start), .clr_wr(clr_wr), .clr_wdata(clr_wdata),
        .status(st1), .clr_rdata(cr1));

    sercha_status #(.CHAN_IDX(0)) u_dut_ch0 (
        .clk(clk), .rst_n(rst_n), .xfer_busy(xfer_busy), .rx_enable(rx_enable),
        .uart_frame_end(uart_frame_end), .uart_stop_ok(uart_stop_ok), .uart_par_ok(uart_par_ok),
        .i2c_tx_mode(i2c_tx_mode), .i2c_ack_slot(i2c_ack_slot), .i2c_ack_seen(i2c_ack_seen),
        .tx_wr(tx_wr), .rx_store(rx_store), .cpu_rd(cpu_rd), .tx_take(tx_take),
        .csi_slv_tx_start(csi_slv_tx_start), .clr_wr(clr_wr), .clr_wdata(clr_wdata),
        .status(st0), .clr_rdata(cr0));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // one clock with the current strobes, then drop every strobe
    task automatic tick();
        @(posedge clk);
        #1;
        uart_frame_end = 0; i2c_ack_slot = 0; tx_wr = 0; rx_store = 0;
        cpu_rd = 0; tx_take = 0; csi_slv_tx_start = 0; clr_wr = 0; clr_wdata = '0;
    endtask

    task automatic clear_all();
        clr_wr = 1; clr_wdata = 8'hFF; tick();
    endtask

    task automatic empty_buf();
        cpu_rd = 1; tx_take = 1; tick();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        #5;
        chk("R1 reset ch1", st1, 8'h00);
        chk("R1 reset ch0", st0, 8'h00);
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
        tick();
        chk("R1 idle ch1", st1, 8'h00);

        // R2 / R3: all stop/parity outcomes
        for (int c = 0; c < 4; c++) begin
            logic [7:0] e1, e0;
            clear_all();
            uart_frame_end = 1; uart_stop_ok = c[0]; uart_par_ok = c[1];
            tick();
            e1 = {5'b0, ~c[0], ~c[1], 1'b0};
            e0 = {6'b0, ~c[1], 1'b0};
            chk("R2 R3 frame-end ch1", st1, e1);
            chk("R2 R3 frame-end ch0", st0, e0);
            tick();
            chk("R9 flags hold", st1, e1);
        end

        // R4: ack slot sweep
        for (int c = 0; c < 8; c++) begin
            clear_all();
            i2c_tx_mode = c[0]; i2c_ack_seen = c[1]; i2c_ack_slot = c[2];
            tick();
            chk("R4 ack slot", st1, {6'b0, (c[0] & ~c[1] & c[2]), 1'b0});
        end
        i2c_tx_mode = 0; i2c_ack_seen = 0;

        // R5: overrun sweep
        for (int c = 0; c < 8; c++) begin
            empty_buf();
            clear_all();
            rx_enable = c[1];
            if (c[0]) begin rx_store = 1; tick(); end
            if (c[2]) tx_wr = 1; else rx_store = 1;
            tick();
            chk("R5 overrun", st1, {2'b0, 1'b1, 4'b0, (c[0] & c[1])});
        end
        rx_enable = 0;

        // R6: CSI slave start with / without loaded data
        for (int c = 0; c < 2; c++) begin
            empty_buf();
            clear_all();
            if (c == 1) begin tx_wr = 1; tick(); end
            chk("R10 buffer full", st1, {2'b0, c[0], 5'b0});
            csi_slv_tx_start = 1; tx_take = 1;
            tick();
            chk("R6 csi no data", st1, {7'b0, ~c[0]});
        end

        // R7: per-bit clear
        for (int b = 0; b < 3; b++) begin
            empty_buf();
            uart_frame_end = 1; uart_stop_ok = 0; uart_par_ok = 0; csi_slv_tx_start = 1;
            tick();
            chk("R7 all set", st1, 8'h07);
            clr_wr = 1; clr_wdata = 8'h07 & ~(8'h01 << b);
            clr_wdata = ~clr_wdata & 8'h07; // only bit b high
            clr_wdata = clr_wdata | 8'hF8;
            tick();
            chk("R7 one-bit clear", st1, 8'h07 & ~(8'h01 << b));
            clr_wr = 1; clr_wdata = 8'h00; tick();
            chk("R7 zero write no effect", st1, 8'h07 & ~(8'h01 << b));
            chk("R9 clear reg reads 0", cr1, 8'h00);
            clear_all();
        end

        // R8: set and clear on the same edge
        clear_all();
        uart_frame_end = 1; uart_stop_ok = 0; uart_par_ok = 0;
        clr_wr = 1; clr_wdata = 8'hFF;
        tick();
        chk("R8 set wins", st1, 8'h06);
        clear_all();
        chk("R7 clear all", st1, 8'h00);

        // R10: busy, and buffer set wins over clear
        xfer_busy = 1; tick();
        chk("R10 busy", st1, 8'h40);
        xfer_busy = 0; tick();
        chk("R10 busy drop", st1, 8'h00);
        tx_wr = 1; cpu_rd = 1; tick();
        chk("R10 full set wins", st1, 8'h20);
        cpu_rd = 1; tick();
        chk("R10 full cleared by read", st1, 8'h00);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule